// File: doc/BRIEF.md
# Mask Register Access Gate

This block rules on each read or write aimed at a translation-control mask register. Two instruction encodings reach the register: the level-2 name and a level-1 alias. For each request the block looks at the current privilege level and at a set of configuration bits. These are whether the highest level (level 3) exists, whether the feature is present, the top-level enable, the priority-undefined and debug-undefined flags, the nested-virtualisation bit and the host-mode flag. From them it picks one outcome: permitted, undefined, trap to level 2 or trap to level 3. A trap also carries its syndrome class.

A fixed chain of checks is walked in priority order, and the first check that matches decides the outcome. The order is: feature present, level 0, the level-1 rules, level 3, the level-3 enable gate, then permit. The same chain also decides which register a permitted access actually reaches. At level 2 in host mode, the level-1 alias is redirected to the level-2 register. The result is registered one clock after the request strobe, marked by a one-cycle valid pulse, and held until the next request. The register storage and the data transfer belong to neighbouring logic.

A small state machine tracks the response. It has three states:

- ST_IDLE: no request since reset.
- ST_FRESH: a result was captured this cycle.
- ST_HELD: an earlier result is being kept.

Its transitions are:

- Any state goes to ST_FRESH when a request arrives.
- ST_FRESH goes to ST_HELD when no request arrives.
- ST_HELD stays in ST_HELD when no request arrives.
- ST_IDLE stays in ST_IDLE when no request arrives.

Top module: `acc_gate_check`

## Requirements
- R1: When the feature-present input is 0, every matching request yields outcome undefined (code 1).
- R2: A matching request from level 0 (cur_level 0) with the feature present yields undefined.
- R3: At level 1, the level-2 name traps to level 2 (code 2) when nested_virt is 1, and is undefined otherwise.
- R4: At level 2 (either name), and for the level-1 alias at level 1, the level-3 gate applies. When level 3 exists and top_enable is 0, the outcome is undefined if undef_prio is 1. Otherwise it is undefined if undef_debug is 1, and a trap to level 3 (code 3) if not. With the gate open the access is permitted (code 0).
- R5: Both trap outcomes report class 0x18 on resp_class; undefined and permitted outcomes report class 0.
- R6: resp_l2_reg is 1 only for a permitted access that reaches the level-2 register. That is the level-2 name, or the level-1 alias used at level 2 with host_mode 1.
- R7: At level 3, with the feature present, every matching request is permitted.
- R8: req_enc is packed as {op0[1:0], op1[2:0], CRn[3:0], CRm[3:0], op2[2:0]}. The level-2 name is 3,4,2,6,2 and the level-1 alias is 3,0,2,6,2. Any other value gives resp_hit 0, outcome permitted, class 0 and resp_l2_reg 0.
- R9: resp_valid pulses for exactly the cycle after a request. All result outputs change only one cycle after a request and otherwise hold their values.
- R10: After reset, resp_valid, resp_hit, resp_outcome, resp_class, resp_l2_reg and resp_write are all 0.
- R11: resp_write echoes the direction of the captured request, and the direction has no effect on the outcome.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, one cycle per request |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_enc | input | 16 | Encoding {op0,op1,CRn,CRm,op2} |
| cur_level | input | 2 | Current privilege level 0..3 |
| top_level_present | input | 1 | Level 3 is implemented |
| feat_present | input | 1 | Masking feature implemented |
| top_enable | input | 1 | Level-3 enable for the mask registers |
| undef_prio | input | 1 | Undefined takes priority over a level-3 trap |
| undef_debug | input | 1 | Debug state turns a level-3 trap into undefined |
| nested_virt | input | 1 | Nested-virtualisation bit |
| host_mode | input | 1 | Level 2 is running as host |
| resp_valid | output | 1 | One-cycle pulse: new result |
| resp_hit | output | 1 | Encoding matched one of the two names |
| resp_outcome | output | 2 | 0 permit, 1 undefined, 2 trap L2, 3 trap L3 |
| resp_class | output | 6 | Syndrome class for traps |
| resp_l2_reg | output | 1 | Permitted access reaches the level-2 register |
| resp_write | output | 1 | Direction of the captured request |

## Verification
The bench sweeps every combination of name, level and the seven configuration bits, in both directions. Every branch of the priority chain is therefore taken, and each pair of neighbouring checks is driven with both of them matching at once. This shows that the earlier check wins. Because the host-mode, nested-virtualisation and debug bits are toggled in states where they must be ignored, the bench also catches a rule applied at the wrong level. Non-matching encodings differ from the valid ones in a single field each, so every field of the decoder is tested. A quiet cycle after each request confirms the pulse and the hold.

// File: rtl/acc_chk_pkg.sv
package acc_chk_pkg;

    localparam int OP0_W   = 2;
    localparam int OP1_W   = 3;
    localparam int CRN_W   = 4;
    localparam int CRM_W   = 4;
    localparam int OP2_W   = 3;
    localparam int ENC_W   = OP0_W + OP1_W + CRN_W + CRM_W + OP2_W;
    localparam int LEVEL_W = 2;
    localparam int CLASS_W = 6;

    localparam logic [CLASS_W-1:0] TRAP_CLASS = 6'h18;

    typedef enum logic [1:0] {
        OUT_PERMIT  = 2'd0,
        OUT_UNDEF   = 2'd1,
        OUT_TRAP_L2 = 2'd2,
        OUT_TRAP_L3 = 2'd3
    } outcome_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FRESH = 2'd1,
        ST_HELD  = 2'd2
    } fsm_e;

    typedef struct packed {
        logic [OP0_W-1:0] op0;
        logic [OP1_W-1:0] op1;
        logic [CRN_W-1:0] crn;
        logic [CRM_W-1:0] crm;
        logic [OP2_W-1:0] op2;
    } enc_t;

endpackage

// File: rtl/acc_decode.sv
module acc_decode
    import acc_chk_pkg::*;
#(
    parameter logic [OP0_W-1:0] P_OP0    = 2'd3,
    parameter logic [OP1_W-1:0] P_OP1_L2 = 3'd4,
    parameter logic [OP1_W-1:0] P_OP1_L1 = 3'd0,
    parameter logic [CRN_W-1:0] P_CRN    = 4'd2,
    parameter logic [CRM_W-1:0] P_CRM    = 4'd6,
    parameter logic [OP2_W-1:0] P_OP2    = 3'd2
) (
    input  logic [ENC_W-1:0] enc,
    output logic             hit,
    output logic             name_l2
);
    enc_t f;
    logic common_ok;
    logic is_l2;
    logic is_l1;

    always_comb begin
        f         = enc_t'(enc);
        common_ok = (f.op0 == P_OP0) && (f.crn == P_CRN) &&
                    (f.crm == P_CRM) && (f.op2 == P_OP2);
        is_l2     = common_ok && (f.op1 == P_OP1_L2);
        is_l1     = common_ok && (f.op1 == P_OP1_L1);
        hit       = is_l2 || is_l1;
        name_l2   = is_l2;
    end
endmodule

// File: rtl/acc_priority.sv
module acc_priority
    import acc_chk_pkg::*;
(
    input  logic               name_l2,
    input  logic [LEVEL_W-1:0] level,
    input  logic               has_top,
    input  logic               feat,
    input  logic               top_en,
    input  logic               prio_undef,
    input  logic               dbg_undef,
    input  logic               nested,
    input  logic               host,
    output outcome_e           outcome,
    output logic               tgt_l2
);
    localparam logic [LEVEL_W-1:0] LV0 = LEVEL_W'(0);
    localparam logic [LEVEL_W-1:0] LV1 = LEVEL_W'(1);
    localparam logic [LEVEL_W-1:0] LV3 = LEVEL_W'(3);

    logic top_gate_shut;
    outcome_e gate_out;

    always_comb begin
        top_gate_shut = has_top && !top_en;
        if (top_gate_shut && prio_undef)      gate_out = OUT_UNDEF;
        else if (top_gate_shut && dbg_undef)  gate_out = OUT_UNDEF;
        else if (top_gate_shut)               gate_out = OUT_TRAP_L3;
        else                                  gate_out = OUT_PERMIT;
    end

    always_comb begin
        outcome = OUT_PERMIT;
        tgt_l2  = 1'b0;
        if (!feat) begin
            outcome = OUT_UNDEF;
        end else if (level == LV0) begin
            outcome = OUT_UNDEF;
        end else if (level == LV1 && name_l2) begin
            outcome = nested ? OUT_TRAP_L2 : OUT_UNDEF;
        end else if (level == LV3) begin
            outcome = OUT_PERMIT;
            tgt_l2  = name_l2;
        end else begin
            outcome = gate_out;
            tgt_l2  = (gate_out == OUT_PERMIT) &&
                      (name_l2 || (level == LEVEL_W'(2) && host));
        end
    end
endmodule

// File: rtl/acc_gate_check.sv
module acc_gate_check
    import acc_chk_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [ENC_W-1:0]   req_enc,
    input  logic [LEVEL_W-1:0] cur_level,
    input  logic               top_level_present,
    input  logic               feat_present,
    input  logic               top_enable,
    input  logic               undef_prio,
    input  logic               undef_debug,
    input  logic               nested_virt,
    input  logic               host_mode,
    output logic               resp_valid,
    output logic               resp_hit,
    output logic [1:0]         resp_outcome,
    output logic [CLASS_W-1:0] resp_class,
    output logic               resp_l2_reg,
    output logic               resp_write
);
    logic     dec_hit;
    logic     dec_l2;
    outcome_e pri_out;
    logic     pri_tgt;
    fsm_e     state_q;
    fsm_e     state_d;
    outcome_e out_q;
    logic     is_trap;

    acc_decode u_dec (
        .enc     (req_enc),
        .hit     (dec_hit),
        .name_l2 (dec_l2)
    );

    acc_priority u_pri (
        .name_l2    (dec_l2),
        .level      (cur_level),
        .has_top    (top_level_present),
        .feat       (feat_present),
        .top_en     (top_enable),
        .prio_undef (undef_prio),
        .dbg_undef  (undef_debug),
        .nested     (nested_virt),
        .host       (host_mode),
        .outcome    (pri_out),
        .tgt_l2     (pri_tgt)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  state_d = req_valid ? ST_FRESH : ST_IDLE;
            ST_FRESH: state_d = req_valid ? ST_FRESH : ST_HELD;
            ST_HELD:  state_d = req_valid ? ST_FRESH : ST_HELD;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb is_trap = (pri_out == OUT_TRAP_L2) || (pri_out == OUT_TRAP_L3);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_hit    <= 1'b0;
            out_q       <= OUT_PERMIT;
            resp_class  <= '0;
            resp_l2_reg <= 1'b0;
            resp_write  <= 1'b0;
        end else if (req_valid) begin
            resp_hit    <= dec_hit;
            out_q       <= dec_hit ? pri_out : OUT_PERMIT;
            resp_class  <= (dec_hit && is_trap) ? TRAP_CLASS : '0;
            resp_l2_reg <= dec_hit && pri_tgt;
            resp_write  <= req_write;
        end
    end

    always_comb begin
        resp_valid   = (state_q == ST_FRESH);
        resp_outcome = out_q;
    end

    AST_NOFEAT_UNDEF: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && dec_hit && !feat_present |=> resp_outcome == OUT_UNDEF); // R1
    AST_LEVEL0_UNDEF: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && dec_hit && feat_present && cur_level == '0
        |=> resp_outcome == OUT_UNDEF); // R2
    AST_TRAP_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
        resp_outcome[1] |-> resp_class == TRAP_CLASS); // R5
    AST_NOTRAP_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
        !resp_outcome[1] |-> resp_class == '0); // R5
    AST_TOP_PERMIT: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && dec_hit && feat_present && cur_level == 2'd3
        |=> resp_outcome == OUT_PERMIT); // R7
    AST_MISS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !dec_hit |=> !resp_hit && resp_outcome == OUT_PERMIT
                                  && !resp_l2_reg); // R8
    AST_PULSE_ON: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> resp_valid); // R9
    AST_PULSE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !resp_valid); // R9
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> $stable(resp_outcome) && $stable(resp_class) &&
                       $stable(resp_l2_reg) && $stable(resp_hit)); // R9
    AST_L2REG_PERMIT: assert property (@(posedge clk) disable iff (!rst_n)
        resp_l2_reg |-> resp_outcome == OUT_PERMIT); // R6
endmodule

// File: tb/tb_acc_gate_check.sv
module tb_acc_gate_check;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [15:0] req_enc = '0;
    logic [1:0]  cur_level = '0;
    logic        top_level_present = 1'b0;
    logic        feat_present = 1'b0;
    logic        top_enable = 1'b0;
    logic        undef_prio = 1'b0;
    logic        undef_debug = 1'b0;
    logic        nested_virt = 1'b0;
    logic        host_mode = 1'b0;
    logic        resp_valid;
    logic        resp_hit;
    logic [1:0]  resp_outcome;
    logic [5:0]  resp_class;
    logic        resp_l2_reg;
    logic        resp_write;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    localparam logic [15:0] ENC_L2 = {2'd3, 3'd4, 4'd2, 4'd6, 3'd2};
    localparam logic [15:0] ENC_L1 = {2'd3, 3'd0, 4'd2, 4'd6, 3'd2};

    always #10 clk = ~clk;

    acc_gate_check dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_enc(req_enc), .cur_level(cur_level),
        .top_level_present(top_level_present), .feat_present(feat_present),
        .top_enable(top_enable), .undef_prio(undef_prio),
        .undef_debug(undef_debug), .nested_virt(nested_virt),
        .host_mode(host_mode), .resp_valid(resp_valid), .resp_hit(resp_hit),
        .resp_outcome(resp_outcome), .resp_class(resp_class),
        .resp_l2_reg(resp_l2_reg), .resp_write(resp_write)
    );

    task automatic check(input string tag, input logic [10:0] act,
                         input logic [10:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [10:0] pack_out();
        return {resp_valid, resp_hit, resp_outcome, resp_class, resp_l2_reg};
    endfunction

    task automatic model(input bit nl2, input bit [1:0] lv, input bit has3,
                         input bit feat, input bit top, input bit prio,
                         input bit dbg, input bit nv, input bit host,
                         output bit [1:0] oc, output bit tgt, output string tag);
        bit shut;
        shut = has3 && !top;
        oc = 2'd0;
        tgt = 1'b0;
        if (!feat) begin
            oc = 2'd1; tag = "R1";
        end else if (lv == 2'd0) begin
            oc = 2'd1; tag = "R2";
        end else if (lv == 2'd1 && nl2) begin
            oc = nv ? 2'd2 : 2'd1; tag = "R3";
        end else if (lv == 2'd3) begin
            oc = 2'd0; tgt = nl2; tag = "R7";
        end else if (shut) begin
            oc = (prio || dbg) ? 2'd1 : 2'd3; tag = "R4";
        end else begin
            oc = 2'd0;
            tgt = nl2 || (lv == 2'd2 && host);
            tag = (lv == 2'd2 && !nl2) ? "R6" : "R4";
        end
    endtask

    task automatic issue_and_check(input string tag, input logic [10:0] exp,
                                   input bit wr);
        logic [10:0] held;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check({tag, "/R5"}, pack_out(), exp);
        check("R11 direction echo", {10'd0, resp_write}, {10'd0, wr});
        held = pack_out();
        @(negedge clk);
        check("R9 hold after pulse", pack_out(), {1'b0, held[9:0]});
    endtask

    initial begin
        @(negedge clk);
        @(negedge clk);
        check("R10 reset outputs", pack_out(), 11'd0);
        check("R10 reset write", {10'd0, resp_write}, 11'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9 idle no pulse", pack_out(), 11'd0);

        for (int i = 0; i < 2048; i++) begin
            bit [1:0] oc;
            bit tgt;
            string tag;
            bit nl2;
            nl2 = i[0];
            req_enc = nl2 ? ENC_L2 : ENC_L1;
            cur_level = i[2:1];
            top_level_present = i[3];
            feat_present = i[4];
            top_enable = i[5];
            undef_prio = i[6];
            undef_debug = i[7];
            nested_virt = i[8];
            host_mode = i[9];
            req_write = i[10];
            model(nl2, i[2:1], i[3], i[4], i[5], i[6], i[7], i[8], i[9],
                  oc, tgt, tag);
            issue_and_check(tag,
                {1'b1, 1'b1, oc, (oc[1] ? 6'h18 : 6'h00), tgt}, i[10]);
        end

        feat_present = 1'b1;
        cur_level = 2'd3;
        top_level_present = 1'b0;
        foreach (req_enc[k]) begin
        end
        for (int m = 0; m < 6; m++) begin
            logic [15:0] e;
            case (m)
                0: e = {2'd2, 3'd4, 4'd2, 4'd6, 3'd2};
                1: e = {2'd3, 3'd1, 4'd2, 4'd6, 3'd2};
                2: e = {2'd3, 3'd4, 4'd3, 4'd6, 3'd2};
                3: e = {2'd3, 3'd4, 4'd2, 4'd7, 3'd2};
                4: e = {2'd3, 3'd4, 4'd2, 4'd6, 3'd3};
                default: e = {2'd3, 3'd0, 4'd2, 4'd6, 3'd0};
            endcase
            req_enc = e;
            req_write = m[0];
            issue_and_check("R8 non-matching encoding", {1'b1, 10'd0}, m[0]);
        end

        req_enc = ENC_L2;
        req_write = 1'b0;
        cur_level = 2'd1;
        nested_virt = 1'b1;
        req_valid = 1'b1;
        @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        check("R9 back-to-back pulse", pack_out(),
              {1'b1, 1'b1, 2'd2, 6'h18, 1'b0});

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule